// File: doc/BRIEF.md
# Multi-Phase Retriggerable One-Shot

This block produces a single output pulse of programmable length each time an asynchronous trigger rises. A new rising edge during an active pulse restarts the pulse at its full length. The trigger is not tied to any clock. One clock would therefore add up to a whole period of timing uncertainty to the output. To avoid that, the block takes several copies of one base clock, spread evenly over a period (four phases a quarter period apart by default). Each phase clock has its own lane. A lane synchronises the trigger, detects its rising edge and runs its own down-counter, and it never uses another phase's clock.

The lane outputs are ORed into the block output. The output therefore rises with the first lane that noticed the trigger edge. The delay from trigger to output has a fixed part: the synchronizer depth plus one load cycle. On top of that it varies only by the gap between the trigger and the next phase edge, which is less than one phase step. The pulse length applies to every lane. It is sampled by each lane when that lane detects an edge, so it should be changed only while no trigger edge is in flight. Generating the phase clocks belongs to the surrounding design.

Top module: `mphase_oneshot`

## Requirements
- R1: Reset is active-low and asynchronous. While it is asserted, every synchronizer stage, edge register and counter in all lanes is clear and `pulse_out` is 0. This holds even when reset is applied in the middle of a pulse.
- R2: With SYNC_STAGES=2, `pulse_out` rises on the third rising edge of the earliest phase clock whose rising edge comes strictly after the trigger's rising edge. That is two synchronizer stages plus one load edge.
- R3: Across trigger edges at arbitrary sub-period offsets, the trigger-to-output-rise delay varies by less than one phase step. With four phases this is a quarter of the base period.
- R4: Each lane's local output is high for exactly `pulse_len` periods of its own clock, counted from its load edge. `pulse_out` is the OR of all lane outputs, so it falls when the last lane expires.
- R5: A new trigger rising edge seen during an active pulse reloads each lane to the full `pulse_len`. This extends the pulse with no gap.
- R6: A `pulse_len` of 0 produces no output pulse at all.
- R7: Only rising edges trigger. A trigger held high starts exactly one pulse, and that pulse ends after `pulse_len` periods even though the trigger stays high.
- R8: A lane samples `pulse_len` only on its load edge. A change to `pulse_len` during an active pulse does not alter the running pulse's length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ph | input | NUM_PHASES | Phase clocks. Bit k lags bit 0 by k/NUM_PHASES of a period |
| rst_n | input | 1 | Asynchronous active-low reset for all lanes |
| trig_async | input | 1 | Asynchronous trigger; rising edges start or restart the pulse |
| pulse_len | input | CNT_W | Pulse length in base clock periods; 0 disables the output |
| pulse_out | output | 1 | One-shot output, the OR of all lane outputs |

## Verification
The embedded assertions watch each lane on its own clock on every cycle. They check that a detected edge loads the counter, or keeps it idle when the length is zero. They also check that a running pulse never drops early, that an idle lane never starts without an edge, and that the last synchronizer stage only rises after the stage before it. What no single-clock property can show is the relation across lanes. That covers the output rising with the earliest phase, the spread of the delay staying below one phase step, and the fall following the latest lane. The bench shows these with trigger edges at random sub-nanosecond offsets, compared against an interval model in continuous time. Retrigger extension, held-high triggers, length changes mid-pulse and reset mid-pulse are exercised as scenarios.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;
   // Default geometry for the multi-phase one-shot
   localparam int unsigned DEF_PHASES      = 4;
   localparam int unsigned DEF_CNT_W       = 16;
   localparam int unsigned DEF_SYNC_STAGES = 2;

   // Fixed part of the trigger-to-output delay, in base clock periods:
   // synchronizer depth plus the load edge, minus the first capture edge.
   function automatic int unsigned fixed_latency_periods(input int unsigned stages);
      return stages;
   endfunction
endpackage

// File: rtl/os_sync.sv
module os_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_async,
   output logic q_sync
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("os_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_async};
   end

   assign q_sync = chain_q[STAGES-1];

   // The output stage can only rise after the stage before it was high (R2)
   assert_chain_order_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(chain_q[STAGES-1]) |-> $past(chain_q[STAGES-2]));
endmodule

// File: rtl/os_phase_counter.sv
module os_phase_counter #(
   parameter int unsigned CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lvl_sync,
   input  logic [CNT_W-1:0] len_i,
   output logic             active_o
);
   logic             prev_q;
   logic             rise;
   logic [CNT_W-1:0] cnt_q;

   generate
      if (CNT_W < 1) begin : g_bad_width
         $error("os_phase_counter: CNT_W must be at least 1");
      end
   endgenerate

   assign rise = lvl_sync & ~prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= 1'b0;
         cnt_q  <= '0;
      end else begin
         prev_q <= lvl_sync;
         if (rise)
            cnt_q <= len_i;
         else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
      end
   end

   assign active_o = (cnt_q != '0);

   // Edge with nonzero length starts or restarts the local pulse (R5)
   assert_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && len_i != '0) |=> active_o);

   // Edge with zero length leaves the lane idle (R6)
   assert_zero_len_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rise && len_i == '0) |=> !active_o);

   // A running pulse does not end before its last count (R4)
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (active_o && cnt_q != 1 && !rise) |=> active_o);

   // An idle lane never starts without a detected edge (R7)
   assert_no_spurious_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!active_o && !rise) |=> !active_o);
endmodule

// File: rtl/mphase_oneshot.sv
module mphase_oneshot
   import oneshot_pkg::*;
#(
   parameter int unsigned NUM_PHASES  = DEF_PHASES,
   parameter int unsigned CNT_W       = DEF_CNT_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC_STAGES
) (
   input  logic [NUM_PHASES-1:0] clk_ph,
   input  logic                  rst_n,
   input  logic                  trig_async,
   input  logic [CNT_W-1:0]      pulse_len,
   output logic                  pulse_out
);
   localparam int unsigned LAT_PERIODS = fixed_latency_periods(SYNC_STAGES);

   logic [NUM_PHASES-1:0] lane_lvl;
   logic [NUM_PHASES-1:0] lane_act;

   generate
      if (NUM_PHASES < 1) begin : g_bad_phases
         $error("mphase_oneshot: NUM_PHASES must be at least 1");
      end
      if (LAT_PERIODS < 2) begin : g_bad_latency
         $error("mphase_oneshot: synchronizer needs two or more stages");
      end

      for (genvar k = 0; k < NUM_PHASES; k++) begin : g_lane
         os_sync #(
            .STAGES (SYNC_STAGES)
         ) u_sync (
            .clk     (clk_ph[k]),
            .rst_n   (rst_n),
            .d_async (trig_async),
            .q_sync  (lane_lvl[k])
         );

         os_phase_counter #(
            .CNT_W (CNT_W)
         ) u_cnt (
            .clk      (clk_ph[k]),
            .rst_n    (rst_n),
            .lvl_sync (lane_lvl[k]),
            .len_i    (pulse_len),
            .active_o (lane_act[k])
         );
      end
   endgenerate

   assign pulse_out = |lane_act;
endmodule

// File: tb/mphase_oneshot_test.sv
`timescale 1ns/1ps
module mphase_oneshot_test;
   localparam int  NPH  = 4;
   localparam int  CW   = 16;
   localparam real TPER = 8.0;            // 125 MHz phase clocks
   localparam real STEP = TPER / NPH;     // 2 ns between phases
   localparam real T0   = 1.0;            // first edge of phase 0
   localparam real LAT  = 2.0 * TPER;     // two sync stages, load on third edge

   logic [NPH-1:0] clk_ph;
   logic           rst_n;
   logic           trig;
   logic [CW-1:0]  len;
   logic           pulse_out;

   int  checks = 0;
   int  errors = 0;
   bit  done   = 0;
   int  n_rise = 0;
   real rise_t = 0.0;
   real fall_t = 0.0;
   real lat_min = 1.0e9;
   real lat_max = -1.0e9;
   real ms[$];
   real me[$];

   mphase_oneshot #(.NUM_PHASES(NPH), .CNT_W(CW), .SYNC_STAGES(2)) uut (
      .clk_ph     (clk_ph),
      .rst_n      (rst_n),
      .trig_async (trig),
      .pulse_len  (len),
      .pulse_out  (pulse_out)
   );

   for (genvar k = 0; k < NPH; k++) begin : g_clk
      logic ck;
      initial begin
         ck = 1'b0;
         #(T0 + STEP * k);
         forever begin
            ck = 1'b1;
            #(TPER / 2.0);
            ck = 1'b0;
            #(TPER / 2.0);
         end
      end
      assign clk_ph[k] = ck;
   end

   always @(posedge pulse_out) begin
      n_rise++;
      rise_t = $realtime;
   end
   always @(negedge pulse_out) fall_t = $realtime;

   function automatic real edge_after(input real r, input int k);
      real e0, n;
      e0 = T0 + STEP * k;
      n  = $floor((r - e0) / TPER) + 1.0;
      return e0 + n * TPER;
   endfunction

   function automatic bit model_out(input real t);
      foreach (ms[i]) if (ms[i] <= t && t < me[i]) return 1'b1;
      return 1'b0;
   endfunction

   function automatic real model_end();
      real m = 0.0;
      foreach (me[i]) if (me[i] > m) m = me[i];
      return m;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input real act, input real exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s at %0.3f ns: actual %0.3f expected %0.3f",
                  req, what, $realtime, act, exp);
      end
   endtask

   // Continuous-time reference, sampled half a nanosecond after every phase edge
   initial begin
      #(T0 + 0.5);
      forever begin
         if (!rst_n)
            check(pulse_out === 1'b0, "R1", "output in reset", real'(pulse_out), 0.0);
         else
            check(pulse_out === model_out($realtime), "R4", "output vs model",
                  real'(pulse_out), real'(model_out($realtime)));
         #STEP;
      end
   end

   // Trigger rise at a random offset that stays clear of every phase edge
   task automatic fire(input real hold, output real r);
      real u;
      @(posedge clk_ph[0]);
      u = 2.0 * ($urandom % 4) + 0.05 + ($urandom % 190) / 100.0;
      #u;
      r = $realtime;
      trig = 1'b1;
      for (int k = 0; k < NPH; k++) begin
         ms.push_back(edge_after(r, k) + LAT);
         me.push_back(edge_after(r, k) + LAT + TPER * len);
      end
      #hold;
      trig = 1'b0;
   endtask

   function automatic real exp_rise(input real r);
      real m = 1.0e9;
      for (int k = 0; k < NPH; k++) if (edge_after(r, k) + LAT < m) m = edge_after(r, k) + LAT;
      return m;
   endfunction

   task automatic set_len(input int v);
      @(posedge clk_ph[0]);
      #1.0;
      len = CW'(v);
   endtask

   initial begin
      #(200000 * TPER);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired at %0.3f ns", $realtime);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      real r, r2, e;
      int  nr;
      rst_n = 1'b0;
      trig  = 1'b0;
      len   = CW'(10);
      #40.0;
      check(pulse_out === 1'b0, "R1", "reset value", real'(pulse_out), 0.0);
      @(posedge clk_ph[0]);
      #1.0;
      rst_n = 1'b1;
      #40.0;
      check(pulse_out === 1'b0, "R1", "idle after reset", real'(pulse_out), 0.0);

      // R2 R3 R4: isolated events, random offsets and lengths
      for (int i = 0; i < 24; i++) begin
         set_len(3 + ($urandom % 10));
         nr = n_rise;
         fire(12.0, r);
         #(LAT + TPER * len + 40.0);
         check(n_rise == nr + 1, "R2", "one rise per edge", real'(n_rise - nr), 1.0);
         check(rise_t - exp_rise(r) < 0.01 && exp_rise(r) - rise_t < 0.01,
               "R2", "rise time", rise_t, exp_rise(r));
         if (rise_t - r < lat_min) lat_min = rise_t - r;
         if (rise_t - r > lat_max) lat_max = rise_t - r;
         e = model_end();
         check(fall_t - e < 0.01 && e - fall_t < 0.01, "R4", "fall time", fall_t, e);
      end
      check(lat_max - lat_min < STEP, "R3", "latency spread", lat_max - lat_min, STEP);
      check(lat_min > LAT, "R3", "latency floor", lat_min, LAT);

      // R5: retrigger in the middle of a pulse
      set_len(10);
      nr = n_rise;
      fire(12.0, r);
      #30.0;
      fire(12.0, r2);
      #(LAT + TPER * 10 + 40.0);
      e = model_end();
      check(n_rise == nr + 1, "R5", "no gap on retrigger", real'(n_rise - nr), 1.0);
      check(fall_t - e < 0.01 && e - fall_t < 0.01, "R5", "extended fall", fall_t, e);
      check(fall_t - rise_t > TPER * 10 + 30.0, "R5", "width grew",
            fall_t - rise_t, TPER * 10 + 30.0);

      // R6: zero length gives nothing
      set_len(0);
      nr = n_rise;
      fire(12.0, r);
      #(LAT + 80.0);
      check(n_rise == nr, "R6", "no pulse for zero length", real'(n_rise - nr), 0.0);

      // R7: trigger held high gives one pulse that still ends
      set_len(4);
      nr = n_rise;
      fire(200.0, r);
      #60.0;
      check(n_rise == nr + 1, "R7", "single pulse while held", real'(n_rise - nr), 1.0);
      check(pulse_out === 1'b0, "R7", "pulse ended", real'(pulse_out), 0.0);
      e = model_end();
      check(fall_t - e < 0.01 && e - fall_t < 0.01, "R7", "held fall", fall_t, e);

      // R8: length changed mid-pulse does not alter the running pulse
      set_len(20);
      fire(12.0, r);
      #40.0;
      set_len(2);
      #(TPER * 20 + 40.0);
      e = model_end();
      check(fall_t - e < 0.01 && e - fall_t < 0.01, "R8", "fall unaffected", fall_t, e);

      // R1: reset in the middle of a pulse
      set_len(30);
      fire(12.0, r);
      #60.0;
      check(pulse_out === 1'b1, "R1", "pulse running before reset", real'(pulse_out), 1.0);
      @(posedge clk_ph[0]);
      #1.0;
      rst_n = 1'b0;
      ms.delete();
      me.delete();
      #0.1;
      check(pulse_out === 1'b0, "R1", "async clear", real'(pulse_out), 0.0);
      #40.0;
      @(posedge clk_ph[0]);
      #1.0;
      rst_n = 1'b1;
      #(TPER * 40);
      check(pulse_out === 1'b0, "R1", "stays idle after reset", real'(pulse_out), 0.0);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule